// File: doc/BRIEF.md
# Programmable Flag Pin Controller with Reset-Time Mode Capture

This block drives eight general-purpose flag pins. Software sets the direction of each pin and reads or writes pin levels through two word-addressed registers on a simple register bus. A pin set as an output drives the value held in the data register. A pin set as an input passes through a two-flop synchronizer into the core clock domain before software can read it.

While reset is asserted, every pin is an input. The lower four pins also act as configuration straps. Their levels are captured into a mode field on the first clock edge after reset is released. The field keeps that value until the next reset.

Top module: `pflag_io`

## Requirements
- R1: While `rst_n` is low, `pinOe` and `pinOut` are all zero and the direction register reads 0x00. After release the same holds until a register is written.
- R2: A write with `busWrEn` high to address 0 loads the direction register on that clock edge. Bit i = 1 makes pin i an output (`pinOe[i]` = 1) and 0 makes it an input. Address 0 reads back the direction register.
- R3: A write to address 1 loads the data register on that clock edge, and `pinOut` shows the value from then on.
- R4: Reading address 1 returns, for every pin whose direction bit is 1, the driven data bit, whatever the pad level is.
- R5: Reading address 1 returns, for every input pin, the pad level synchronized through two flops. A pad change made between edges is still absent after the next edge and appears after the second one.
- R6: `modeBits` takes `pinIn[3:0]` as it stood at reset release and holds it unchanged against later pad changes until the next reset. A later reset captures afresh.
- R7: The data register resets to 0x00, so a pin switched to output before any data write drives low.
- R8: Addresses other than 0 and 1 read as 0x00, and writes to them change neither register.
- R9: Bus writes issued while `rst_n` is low have no effect on either register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Register word address (0 direction, 1 data) |
| busWrEn | input | 1 | Write strobe, sampled on the rising edge |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data for `busAddr` |
| pinIn | input | 8 | Pad input levels |
| pinOut | output | 8 | Pad output levels (data register) |
| pinOe | output | 8 | Pad output enables (direction register) |
| modeBits | output | 4 | Configuration bits captured at reset release |

## Verification
The assertions assume that bus address, write strobe and pad levels change only away from the rising edge. They also assume reset is held for at least two clock edges, so that the synchronizer holds real pad values before release. The latency property assumes the two-flop default depth. The bench drives every input on the falling edge, holds reset for several cycles with the pads steady, and reads back only after the input side has been stable for the synchronizer depth, except in the latency test, which samples on purpose after one and after two edges.

// File: rtl/pflag_pkg.sv
package pflag_pkg;
  typedef struct packed {
    logic dirWr;
    logic dataWr;
    logic modeCap;
    logic selDir;
    logic selData;
  } pflag_strb_t;
endpackage

// File: rtl/pflag_ctrl.sv
module pflag_ctrl
  import pflag_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DIR_ADDR  = 0,
  parameter int DATA_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output pflag_strb_t       strb
);
  localparam logic [ADDR_W-1:0] DirA  = ADDR_W'(DIR_ADDR);
  localparam logic [ADDR_W-1:0] DataA = ADDR_W'(DATA_ADDR);

  logic rstDone;

  // rstDone goes high on the first edge after release; modeCap marks that edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rstDone <= 1'b0;
    else        rstDone <= 1'b1;
  end

  always_comb begin
    strb.selDir  = (addr == DirA);
    strb.selData = (addr == DataA);
    strb.dirWr   = rst_n && wrEn && strb.selDir;
    strb.dataWr  = rst_n && wrEn && strb.selData;
    strb.modeCap = rst_n && !rstDone;
  end
endmodule

// File: rtl/pflag_dp.sv
module pflag_dp
  import pflag_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int MODE_BITS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  pflag_strb_t          strb,
  input  logic [NUM_PINS-1:0]  wrData,
  input  logic [NUM_PINS-1:0]  pinIn,
  output logic [NUM_PINS-1:0]  rdData,
  output logic [NUM_PINS-1:0]  pinOut,
  output logic [NUM_PINS-1:0]  pinOe,
  output logic [MODE_BITS-1:0] modeBits
);
  localparam int LastStage = SYNC_STAGES - 1;

  logic [NUM_PINS-1:0] dirReg;
  logic [NUM_PINS-1:0] dataReg;
  logic [NUM_PINS-1:0] syncQ [SYNC_STAGES];
  logic [NUM_PINS-1:0] pinView;

  // synchronizer has no reset so it tracks the straps while reset is held
  always_ff @(posedge clk) syncQ[0] <= pinIn;
  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) syncQ[s] <= syncQ[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirReg  <= '0;
      dataReg <= '0;
    end else begin
      if (strb.dirWr)  dirReg  <= wrData;
      if (strb.dataWr) dataReg <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            modeBits <= '0;
    else if (strb.modeCap) modeBits <= syncQ[LastStage][MODE_BITS-1:0];
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_view
    assign pinView[i] = dirReg[i] ? dataReg[i] : syncQ[LastStage][i];
  end

  always_comb begin
    if (strb.selDir)       rdData = dirReg;
    else if (strb.selData) rdData = pinView;
    else                   rdData = '0;
  end

  assign pinOut = dataReg;
  assign pinOe  = dirReg;
endmodule

// File: rtl/pflag_io.sv
module pflag_io
  import pflag_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int MODE_BITS   = 4,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [NUM_PINS-1:0]  busWrData,
  output logic [NUM_PINS-1:0]  busRdData,
  input  logic [NUM_PINS-1:0]  pinIn,
  output logic [NUM_PINS-1:0]  pinOut,
  output logic [NUM_PINS-1:0]  pinOe,
  output logic [MODE_BITS-1:0] modeBits
);
  pflag_strb_t strb;

  pflag_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .addr(busAddr), .wrEn(busWrEn), .strb(strb)
  );

  pflag_dp #(.NUM_PINS(NUM_PINS), .MODE_BITS(MODE_BITS), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrData(busWrData), .pinIn(pinIn),
    .rdData(busRdData), .pinOut(pinOut), .pinOe(pinOe), .modeBits(modeBits)
  );
endmodule

// File: rtl/pflag_io_chk.sv
module pflag_io_chk #(
  parameter int NUM_PINS    = 8,
  parameter int MODE_BITS   = 4,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busWrEn,
  input logic [NUM_PINS-1:0]  busWrData,
  input logic [NUM_PINS-1:0]  busRdData,
  input logic [NUM_PINS-1:0]  pinIn,
  input logic [NUM_PINS-1:0]  pinOut,
  input logic [NUM_PINS-1:0]  pinOe,
  input logic [MODE_BITS-1:0] modeBits
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_inputs: assert (pinOe == '0 && pinOut == '0);
    end
  end

  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && busAddr == ADDR_W'(0)) |=> pinOe == $past(busWrData));

  a_r3_data_write: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && busAddr == ADDR_W'(1)) |=> pinOut == $past(busWrData));

  a_r4_out_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr == ADDR_W'(1)) |-> ((busRdData ^ pinOut) & pinOe) == '0);

  if (SYNC_STAGES == 2) begin : g_lat
    a_r5_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (busAddr == ADDR_W'(1) && pinOe == '0) |-> busRdData == $past(pinIn, 2));
  end

  a_r6_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2)) |-> $stable(modeBits));

  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr != ADDR_W'(0) && busAddr != ADDR_W'(1)) |-> busRdData == '0);
endmodule

bind pflag_io pflag_io_chk #(
  .NUM_PINS(NUM_PINS), .MODE_BITS(MODE_BITS), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
  .busRdData(busRdData), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .modeBits(modeBits)
);

// File: tb/pflag_io_tb_top.sv
module pflag_io_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {dir, data, pads, expected read at address 1}
  localparam logic [31:0] VEC [NVEC] = '{
    32'h00_00_5A_5A,
    32'hFF_C3_00_C3,
    32'hF0_AB_12_A2,
    32'h0F_5E_E7_EE,
    32'h55_FF_00_55,
    32'hAA_00_FF_55
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic [7:0] pinIn = '0;
  logic [7:0] pinOut;
  logic [7:0] pinOe;
  logic [3:0] modeBits;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pflag_io dut_i (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .modeBits(modeBits)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic doReset(input logic [7:0] pads);
    @(negedge clk);
    pinIn = pads;
    rst_n = 1'b0;
    busAddr = 4'd1; busWrData = 8'hFF; busWrEn = 1'b1;   // R9 stimulus during reset
    cyc(5);
    rst_n = 1'b1;
    busWrEn = 1'b0;
    cyc(2);
  endtask

  initial begin
    logic [7:0] r;
    rst_n = 1'b1;
    #2 rst_n = 1'b0;
    doReset(8'hA5);
    check("R6 mode capture", {4'h0, modeBits}, 8'h05);
    check("R1 oe after reset", pinOe, 8'h00);
    check("R1 out after reset", pinOut, 8'h00);
    rd(4'd0, r); check("R9 dir after reset-time write", r, 8'h00);
    pinIn = 8'h00; cyc(3);
    rd(4'd1, r); check("R9 data after reset-time write", r, 8'h00);
    pinIn = 8'h5A; cyc(4);
    check("R6 mode hold", {4'h0, modeBits}, 8'h05);

    // R7: output before any data write drives low
    pinIn = 8'hFF;
    wr(4'd0, 8'h0F);
    cyc(3);
    check("R7 oe", pinOe, 8'h0F);
    check("R7 out low", pinOut, 8'h00);
    rd(4'd1, r); check("R7 readback", r, 8'hF0);

    // table walk: R2 R3 R4 R5
    for (int v = 0; v < NVEC; v++) begin
      wr(4'd0, VEC[v][31:24]);
      wr(4'd1, VEC[v][23:16]);
      pinIn = VEC[v][15:8];
      cyc(3);
      rd(4'd0, r); check("R2 dir readback", r, VEC[v][31:24]);
      check("R2 oe", pinOe, VEC[v][31:24]);
      check("R3 out", pinOut, VEC[v][23:16]);
      rd(4'd1, r); check("R4/R5 data readback", r, VEC[v][7:0]);
    end

    // R5 latency
    wr(4'd0, 8'h00);
    pinIn = 8'h00; cyc(3);
    busAddr = 4'd1;
    pinIn = 8'h3C;
    cyc(1);
    rd(4'd1, r); check("R5 after one edge", r, 8'h00);
    cyc(1);
    rd(4'd1, r); check("R5 after two edges", r, 8'h3C);

    // R8 unmapped address
    wr(4'd0, 8'h81);
    wr(4'd1, 8'h42);
    wr(4'd2, 8'hFF);
    wr(4'd15, 8'hFF);
    rd(4'd2, r); check("R8 unmapped read", r, 8'h00);
    rd(4'd15, r); check("R8 unmapped read top", r, 8'h00);
    rd(4'd0, r); check("R8 dir untouched", r, 8'h81);
    check("R8 data untouched", pinOut, 8'h42);

    // second reset recaptures
    doReset(8'h0A);
    check("R6 recapture", {4'h0, modeBits}, 8'h0A);
    check("R1 oe after second reset", pinOe, 8'h00);
    check("R1 out after second reset", pinOut, 8'h00);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule